// File: doc/BRIEF.md
# String Element Validity Generator

This block decides which elements of two packed 128-bit string operands take part in a later string comparison. Each operand is split into sixteen byte lanes or eight word lanes. Each lane gets a valid bit, and each operand gets an end-of-string flag. Validity comes from one of two schemes, chosen per operation.

In explicit mode, each operand comes with a signed length. The magnitude of that length, clamped to the lane count, gives the number of leading valid lanes. In implicit mode, the lengths are ignored and the operand is scanned for its lowest zero-valued lane. Every lane below that lane is valid, and that lane and everything above it are not.

The result is registered, so the masks and flags for the inputs sampled at one rising edge appear after that edge. A downstream comparison matrix uses them to force or mask its per-pair results.

Top module: `strval_gen`

## Requirements
- R1: `word_mode`=0 gives 16 lanes of 8 bits each, with lane i at bits [8i+7:8i]. `word_mode`=1 gives 8 lanes of 16 bits each, with lane i at bits [16i+15:16i]. In word mode, mask bits 15..8 are always 0.
- R2: With `explicit_mode`=1, lane i of an operand is valid exactly when i is less than that operand's effective length. The effective length is the absolute value of the two's-complement length input.
- R3: The effective length clamps to the lane count (16 or 8) whenever the magnitude exceeds it. This covers the most negative length value 0x80000000, which must give a full mask.
- R4: With `explicit_mode`=1, an operand's end flag is 1 exactly when its effective length is below the lane count.
- R5: With `explicit_mode`=0, a lane is valid only when no lane at or below its index is zero. The lowest zero lane is itself invalid. An operand with no zero lane is fully valid across the lane count.
- R6: With `explicit_mode`=0, an operand's end flag is 1 exactly when any of its lanes (in the current lane size) is zero. The length inputs have no effect in this mode.
- R7: All outputs are registered. They show the result for the inputs present at the previous rising edge of `clk`. An active-low asynchronous reset clears masks and flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| explicit_mode | input | 1 | 1: length-based validity, 0: zero-terminated validity |
| word_mode | input | 1 | 0: byte lanes, 1: word lanes |
| op_a | input | 128 | First packed operand |
| op_b | input | 128 | Second packed operand |
| len_a | input | 32 | Signed length of first operand |
| len_b | input | 32 | Signed length of second operand |
| valid_a | output | 16 | Lane valid mask of first operand |
| valid_b | output | 16 | Lane valid mask of second operand |
| eos_a | output | 1 | End-of-string flag of first operand |
| eos_b | output | 1 | End-of-string flag of second operand |

## Verification
The bench builds the block with its default parameters: 128-bit operands, 32-bit lengths and 16 byte lanes. This puts the full-width extremes of the length within reach, namely 0x80000000 and 0x7FFFFFFF, along with the exact clamp edges at ±16 and ±8. Random operands are filled with zero lanes at a high rate, so in implicit mode the first null lands in every position and word lanes often contain a zero byte without being zero as a whole.

// File: rtl/strval_gen.sv
module strval_gen #(
  parameter int OPW   = 128,
  parameter int LENW  = 32,
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             explicit_mode,
  input  logic             word_mode,
  input  logic [OPW-1:0]   op_a,
  input  logic [OPW-1:0]   op_b,
  input  logic [LENW-1:0]  len_a,
  input  logic [LENW-1:0]  len_b,
  output logic [LANES-1:0] valid_a,
  output logic [LANES-1:0] valid_b,
  output logic             eos_a,
  output logic             eos_b
);
  localparam int BW    = OPW / LANES;
  localparam int WL    = LANES / 2;
  localparam int CNTW  = $clog2(LANES + 1);
  localparam int MAGW  = LENW + 1;

  function automatic logic [LANES-1:0] zero_lanes(input logic [OPW-1:0] op, input logic wd);
    logic [LANES-1:0] z;
    z = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!wd) z[i] = (op[i*BW +: BW] == '0);
      else if (i < WL) z[i] = (op[i*2*BW +: 2*BW] == '0);
    end
    return z;
  endfunction

  function automatic logic [CNTW-1:0] clamp_len(input logic [LENW-1:0] len, input logic [CNTW-1:0] cap);
    logic [MAGW-1:0] mag;
    mag = len[LENW-1] ? ({1'b0, ~len} + MAGW'(1)) : {1'b0, len};
    return (mag > MAGW'(cap)) ? cap : mag[CNTW-1:0];
  endfunction

  function automatic logic [LANES-1:0] therm(input logic [CNTW-1:0] n);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (CNTW'(i) < n);
    return m;
  endfunction

  function automatic logic [LANES-1:0] before_null(input logic [LANES-1:0] z, input logic [CNTW-1:0] cap);
    logic [LANES-1:0] m;
    logic alive;
    alive = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      alive = alive & ~z[i];
      m[i]  = alive & (CNTW'(i) < cap);
    end
    return m;
  endfunction

  logic [CNTW-1:0]  cap;
  logic [CNTW-1:0]  eff_a, eff_b;
  logic [LANES-1:0] zr_a, zr_b;
  logic [LANES-1:0] va_n, vb_n;
  logic             ea_n, eb_n;

  assign cap   = word_mode ? CNTW'(WL) : CNTW'(LANES);
  assign eff_a = clamp_len(len_a, cap);
  assign eff_b = clamp_len(len_b, cap);
  assign zr_a  = zero_lanes(op_a, word_mode);
  assign zr_b  = zero_lanes(op_b, word_mode);
  assign va_n  = explicit_mode ? therm(eff_a) : before_null(zr_a, cap);
  assign vb_n  = explicit_mode ? therm(eff_b) : before_null(zr_b, cap);
  assign ea_n  = explicit_mode ? (eff_a < cap) : (|zr_a);
  assign eb_n  = explicit_mode ? (eff_b < cap) : (|zr_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_a <= '0;
      valid_b <= '0;
      eos_a   <= 1'b0;
      eos_b   <= 1'b0;
    end else begin
      valid_a <= va_n;
      valid_b <= vb_n;
      eos_a   <= ea_n;
      eos_b   <= eb_n;
    end
  end

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_word_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    primed && word_mode |=> (valid_a[LANES-1:WL] == '0) && (valid_b[LANES-1:WL] == '0));

  assert_prefix_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> ((valid_a & (valid_a + LANES'(1))) == '0) && ((valid_b & (valid_b + LANES'(1))) == '0));

  assert_min_len_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    primed && explicit_mode && (len_a == {1'b1, {(LENW-1){1'b0}}}) |=> valid_a[0] && !eos_a);

  assert_flag_vs_top_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    primed && explicit_mode && !word_mode |=> (eos_a == !valid_a[LANES-1]) && (eos_b == !valid_b[LANES-1]));

  assert_null_lane0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !explicit_mode && !word_mode && (op_a[BW-1:0] == '0) |=> (valid_a == '0) && eos_a);

  assert_no_null_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !explicit_mode |=> (eos_a || valid_a[WL-1]) && (eos_b || valid_b[WL-1]));
endmodule

// File: tb/strval_gen_tb_top.sv
module strval_gen_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         explicit_mode = 1'b0;
  logic         word_mode = 1'b0;
  logic [127:0] op_a = '0, op_b = '0;
  logic [31:0]  len_a = '0, len_b = '0;
  logic [15:0]  valid_a, valid_b;
  logic         eos_a, eos_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strval_gen dut_i (
    .clk(clk), .rst_n(rst_n), .explicit_mode(explicit_mode), .word_mode(word_mode),
    .op_a(op_a), .op_b(op_b), .len_a(len_a), .len_b(len_b),
    .valid_a(valid_a), .valid_b(valid_b), .eos_a(eos_a), .eos_b(eos_b)
  );

  function automatic logic [16:0] ref_one(logic [127:0] op, logic [31:0] len, bit expl, bit wd);
    int n;
    longint m;
    bit stop;
    logic [15:0] mask;
    logic [15:0] elem;
    bit eos;
    n = wd ? 8 : 16;
    mask = '0;
    eos = 0;
    if (expl) begin
      m = longint'($signed(len));
      if (m < 0) m = -m;
      if (m > n) m = n;
      for (int i = 0; i < n; i++) mask[i] = (i < m);
      eos = (m < n);
    end else begin
      stop = 0;
      for (int i = 0; i < n; i++) begin
        elem = wd ? op[16*i +: 16] : {8'h00, op[8*i +: 8]};
        if (elem == 16'h0) stop = 1;
        mask[i] = !stop;
      end
      eos = stop;
    end
    return {eos, mask};
  endfunction

  task automatic cmp(string tag, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(bit expl, bit wd, logic [127:0] a, logic [127:0] b,
                     logic [31:0] la, logic [31:0] lb, string tag);
    logic [16:0] ea, eb;
    @(negedge clk);
    explicit_mode = expl; word_mode = wd;
    op_a = a; op_b = b; len_a = la; len_b = lb;
    ea = ref_one(a, la, expl, wd);
    eb = ref_one(b, lb, expl, wd);
    @(negedge clk);
    cmp({tag, " opA"}, {eos_a, valid_a}, ea);
    cmp({tag, " opB"}, {eos_b, valid_b}, eb);
    if (wd) cmp("R1 word upper zero", {1'b0, valid_a[15:8], valid_b[15:8]}, 17'h0);
  endtask

  function automatic logic [127:0] rand_op(bit wd);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) begin
      v[8*i +: 8] = ($urandom % 5 == 0) ? 8'h00 : 8'($urandom);
    end
    if (wd && ($urandom % 3 == 0)) v[16*($urandom % 8) +: 16] = 16'h0;
    return v;
  endfunction

  function automatic logic [31:0] rand_len();
    int k;
    k = $urandom % 4;
    if (k == 0) return 32'($urandom);
    return 32'(int'($urandom % 41) - 20);
  endfunction

  initial begin
    logic [127:0] full;
    bit e, w;
    void'($urandom(32'd20240601));
    full = {16{8'h5A}};
    repeat (3) @(negedge clk);
    checks++;
    if ({eos_a, eos_b, valid_a, valid_b} !== 34'h0) begin
      errors++;
      $display("FAIL R7 reset actual=%h expected=0", {eos_a, eos_b, valid_a, valid_b});
    end
    rst_n = 1'b1;

    run(1, 0, full, full, 32'd0, 32'd16, "R2 len 0/16");
    run(1, 0, full, full, 32'd5, -32'sd5, "R2 len 5/-5");
    run(1, 0, full, full, 32'd17, -32'sd17, "R3 clamp 17/-17");
    run(1, 0, full, full, 32'h8000_0000, 32'h7FFF_FFFF, "R3 extreme lengths");
    run(1, 0, full, full, -32'sd16, 32'd15, "R4 flag -16/15");
    run(1, 1, full, full, 32'd8, 32'd9, "R4 word 8/9");
    run(1, 1, full, full, -32'sd8, 32'h8000_0000, "R3 word -8/min");
    run(1, 1, full, full, 32'd3, -32'sd1, "R2 word 3/-1");
    run(0, 0, {full[127:8], 8'h00}, full, 32'd0, 32'd0, "R5 null lane0/none");
    run(0, 0, {8'h00, full[119:0]}, {full[127:48], 8'h00, full[39:0]}, 32'd3, 32'd3, "R6 null top/lane5");
    run(0, 1, {full[127:16], 16'h0100}, {full[127:32], 16'h0000, full[15:0]}, 32'd2, 32'd2, "R5 word partial zero");
    run(0, 1, full, {16'h0000, full[111:0]}, 32'd0, 32'd0, "R6 word top null");
    run(0, 0, 128'h0, full, 32'd16, 32'd16, "R5 all zero");

    for (int t = 0; t < 3000; t++) begin
      e = 1'($urandom);
      w = 1'($urandom);
      run(e, w, rand_op(w), rand_op(w), rand_len(), rand_len(),
          e ? "R2 R4 random explicit" : "R5 R6 random implicit");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule